// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

The block latches level-sensitive interrupt requests from two groups of 32 sources: a primary group and a secondary peripheral group. Each group keeps a sticky status register and an enable mask. A status bit is cleared by writing a 1 to it. The secondary group does not have its own processor line. It is folded into one reserved bit of the primary group (index 31 by default), and that bit is high whenever any enabled secondary source is pending.

A single registered interrupt line goes to the processor. Software reads a vector register to find out which source to service. The lowest-numbered pending primary bit wins. The vector descends into the secondary group only when the cascade bit is the only primary bit pending. Secondary sources are reported with numbers 32 to 63. When nothing is pending, the vector carries a spurious flag instead of a valid number.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After synchronous reset, all four status/mask registers read 0, `cpu_irq` is 0, and the vector register reads 0x8000_0000 (spurious).
- R2: A status bit (primary offset 0x00, secondary offset 0x08) becomes 1 on any clock edge where its request input is high, whatever the mask says. It stays 1 after the request drops.
- R3: A write to a status offset clears each bit written as 1 and leaves bits written as 0 unchanged. If the request is still high on the edge of the clearing write, the bit stays 1.
- R4: The mask registers (primary 0x04, secondary 0x0C) read back what was written. A group's pending vector is status AND mask.
- R5: Primary status bit 31 reads 1 exactly when the secondary pending vector is non-zero. The primary request input bit 31 and clear writes to that bit have no effect on it.
- R6: `cpu_irq` is 1 one clock after the primary pending vector is non-zero, and 0 one clock after it becomes zero.
- R7: The vector register (0x10) holds the source number in bits [5:0] and the spurious flag in bit 31, with all other bits 0. Within the primary group, the lowest-numbered pending bit is reported.
- R8: When the primary pending vector equals only bit 31, the vector reports 32 plus the index of the lowest pending secondary bit.
- R9: When the selected pending vector is zero, bit 31 of the vector is 1 and the number field is 0.
- R10: When bit 31 and any other primary bit are both pending, the vector reports the primary bit and not a secondary source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_req | input | 32 | Level requests of the primary group (bit 31 unused) |
| sec_req | input | 32 | Level requests of the secondary group |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| cpu_irq | output | 1 | Registered interrupt line to the processor |

## Verification
Single primary requests are first left unmasked and then masked. This separates the sticky status from the pending path and the registered line. Two pending primary bits, with one of them cleared afterwards, show that the lowest index wins. Secondary bits 8 and 11 are tested in three cases: cascade bit alone, cascade bit together with a lower primary bit, and after partial clears. These cases separate the exact-equality descent rule from a plain priority scan. Holding a request through its own clear write, and driving primary request bit 31, show that the set has priority and that the cascade bit ignores direct writes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned GRP_W  = 32;
    localparam int unsigned IDX_W  = $clog2(GRP_W);
    localparam int unsigned NUM_W  = IDX_W + 1;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PRI_STAT = 5'h00,
        OFS_PRI_MASK = 5'h04,
        OFS_SEC_STAT = 5'h08,
        OFS_SEC_MASK = 5'h0C,
        OFS_VECTOR   = 5'h10
    } reg_ofs_e;

    typedef struct packed {
        logic             spurious;
        logic [NUM_W-1:0] num;
    } vec_t;

    function automatic logic [IDX_W-1:0] lowest_idx(input logic [GRP_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned W         = GRP_W,
    parameter logic [W-1:0] LIVE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req,
    input  logic         stat_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            assign stat[i] = req[i];
        end else begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)                        bit_q <= 1'b0;
                else if (req[i])                bit_q <= 1'b1;
                else if (stat_we && wdata[i])   bit_q <= 1'b0;
            end
            assign stat[i] = bit_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (mask_we) mask <= wdata;
    end

    assign pend = stat & mask;

endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned CASC_IDX = GRP_W - 1
) (
    input  logic [GRP_W-1:0] pri_pend,
    input  logic [GRP_W-1:0] sec_pend,
    output vec_t             vec
);

    localparam logic [GRP_W-1:0] CASC_ONLY = GRP_W'(1) << CASC_IDX;

    logic             use_sec;
    logic [GRP_W-1:0] chosen;

    always_comb begin
        use_sec = (pri_pend == CASC_ONLY);
        chosen  = use_sec ? sec_pend : pri_pend;
        vec     = '0;
        if (chosen == '0) begin
            vec.spurious = 1'b1;
        end else begin
            vec.num = {use_sec, lowest_idx(chosen)};
        end
    end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned CASC_IDX = GRP_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GRP_W-1:0]  pri_req,
    input  logic [GRP_W-1:0]  sec_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    localparam logic [GRP_W-1:0] CASC_BIT = GRP_W'(1) << CASC_IDX;

    logic [GRP_W-1:0] pri_stat, pri_mask, pri_pend, pri_req_eff;
    logic [GRP_W-1:0] sec_stat, sec_mask, sec_pend;
    vec_t             vec;

    always_comb begin
        pri_req_eff           = pri_req;
        pri_req_eff[CASC_IDX] = |sec_pend;
    end

    irq_bank #(.W(GRP_W), .LIVE_MASK(CASC_BIT)) i_pri_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (pri_req_eff),
        .stat_we (bus_wr && bus_addr == OFS_PRI_STAT),
        .mask_we (bus_wr && bus_addr == OFS_PRI_MASK),
        .wdata   (bus_wdata),
        .stat    (pri_stat),
        .mask    (pri_mask),
        .pend    (pri_pend)
    );

    irq_bank #(.W(GRP_W), .LIVE_MASK('0)) i_sec_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (sec_req),
        .stat_we (bus_wr && bus_addr == OFS_SEC_STAT),
        .mask_we (bus_wr && bus_addr == OFS_SEC_MASK),
        .wdata   (bus_wdata),
        .stat    (sec_stat),
        .mask    (sec_mask),
        .pend    (sec_pend)
    );

    irq_vec_sel #(.CASC_IDX(CASC_IDX)) i_vec_sel (
        .pri_pend (pri_pend),
        .sec_pend (sec_pend),
        .vec      (vec)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PRI_STAT: bus_rdata = pri_stat;
            OFS_PRI_MASK: bus_rdata = pri_mask;
            OFS_SEC_STAT: bus_rdata = sec_stat;
            OFS_SEC_MASK: bus_rdata = sec_mask;
            OFS_VECTOR: begin
                bus_rdata[DATA_W-1]  = vec.spurious;
                bus_rdata[NUM_W-1:0] = vec.num;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cpu_irq <= 1'b0;
        else     cpu_irq <= |pri_pend;
    end

endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [GRP_W-1:0]  sec_req,
    input logic [GRP_W-1:0]  sec_stat,
    input logic [GRP_W-1:0]  pri_pend,
    input logic              cpu_irq,
    input logic              vec_spur,
    input logic [NUM_W-1:0]  vec_num
);

    AST_REQ_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sec_stat & $past(sec_req)) == $past(sec_req)));  // R2

    AST_NO_DROP_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_SEC_STAT) |=>
        ((sec_stat & $past(sec_stat)) == $past(sec_stat)));  // R3

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq == $past(|pri_pend)));  // R6

    AST_IDLE_IS_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (pri_pend == '0) |-> vec_spur);  // R9

    AST_SPURIOUS_NUM_ZERO: assert property (@(posedge clk) disable iff (rst)
        vec_spur |-> (vec_num == '0));  // R9

endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .sec_req  (sec_req),
    .sec_stat (sec_stat),
    .pri_pend (pri_pend),
    .cpu_irq  (cpu_irq),
    .vec_spur (vec.spurious),
    .vec_num  (vec.num)
);

// File: tb/test_casc_irq_ctrl.sv
module test_casc_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pri_req = '0;
    logic [31:0] sec_req = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    always #4 clk = ~clk;

    casc_irq_ctrl i_casc_irq_ctrl (
        .clk(clk), .rst(rst), .pri_req(pri_req), .sec_req(sec_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        #2;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        #2;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic pulse_pri(input logic [31:0] v);
        @(negedge clk); pri_req = v;
        @(negedge clk); pri_req = '0;
    endtask

    task automatic pulse_sec(input logic [31:0] v);
        @(negedge clk); sec_req = v;
        @(negedge clk); sec_req = '0;
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {31'b0, cpu_irq} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        expect_reg(5'h00, 32'h0, "R1 pri stat");
        expect_reg(5'h04, 32'h0, "R1 pri mask");
        expect_reg(5'h08, 32'h0, "R1 sec stat");
        expect_reg(5'h0C, 32'h0, "R1 sec mask");
        expect_reg(5'h10, 32'h8000_0000, "R1 vector");
        expect_irq(0, "R1 irq");

        // R2 sticky, masked out
        pulse_pri(32'h0000_0014);
        expect_reg(5'h00, 32'h0000_0014, "R2 pri sticky");
        expect_irq(0, "R6 masked irq low");
        expect_reg(5'h10, 32'h8000_0000, "R9 masked spurious");

        // R4 mask, R6 irq, R7 vector
        wr(5'h04, 32'h0000_0010);
        expect_reg(5'h04, 32'h0000_0010, "R4 mask readback");
        expect_irq(1, "R6 irq high");
        expect_reg(5'h10, 32'd4, "R7 single pending");
        wr(5'h04, 32'h0000_0014);
        expect_reg(5'h10, 32'd2, "R7 lowest wins");

        // R3 write-one-to-clear
        wr(5'h00, 32'h0000_0004);
        expect_reg(5'h00, 32'h0000_0010, "R3 clear one bit");
        expect_reg(5'h10, 32'd4, "R7 after clear");
        wr(5'h00, 32'h0);
        expect_reg(5'h00, 32'h0000_0010, "R3 zero write no effect");
        @(negedge clk); pri_req = 32'h0000_0010;
        wr(5'h00, 32'h0000_0010);
        expect_reg(5'h00, 32'h0000_0010, "R3 set beats clear");
        @(negedge clk); pri_req = '0;
        wr(5'h00, 32'h0000_0010);
        expect_reg(5'h00, 32'h0, "R3 cleared");
        expect_irq(0, "R6 irq low again");
        expect_reg(5'h10, 32'h8000_0000, "R9 idle spurious");

        // R5 cascade, R8 secondary vector
        pulse_sec(32'h0000_0900);
        expect_reg(5'h08, 32'h0000_0900, "R2 sec sticky");
        expect_reg(5'h00, 32'h0, "R5 cascade low when sec masked");
        wr(5'h0C, 32'hFFFF_FFFF);
        expect_reg(5'h00, 32'h8000_0000, "R5 cascade high");
        expect_irq(0, "R6 cascade masked in primary");
        wr(5'h04, 32'h8000_0000);
        expect_irq(1, "R6 irq via cascade");
        expect_reg(5'h10, 32'd40, "R8 secondary vector");
        wr(5'h00, 32'h8000_0000);
        expect_reg(5'h00, 32'h8000_0000, "R5 clear write ignored");

        // R10 cascade plus a primary bit
        wr(5'h04, 32'h8000_0010);
        pulse_pri(32'h0000_0010);
        expect_reg(5'h10, 32'd4, "R10 primary beats cascade");
        wr(5'h00, 32'h0000_0010);
        expect_reg(5'h10, 32'd40, "R8 back to secondary");
        wr(5'h08, 32'h0000_0100);
        expect_reg(5'h10, 32'd43, "R8 next secondary");
        wr(5'h08, 32'h0000_0800);
        expect_reg(5'h00, 32'h0, "R5 cascade drops");
        expect_irq(0, "R6 irq low after secondary cleared");
        expect_reg(5'h10, 32'h8000_0000, "R9 spurious at end");
        pulse_pri(32'h8000_0000);
        expect_reg(5'h00, 32'h0, "R5 request bit 31 ignored");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule